// File: doc/BRIEF.md
# Timeslot One-Wire Pixel Serializer

The block turns a stream of intensity bytes into the waveform of a one-wire LED pixel data line. Every data bit lasts a fixed number of equal slots, each `cfg_div` clock cycles long. A bit always opens with a high slot and closes with a low slot. The number of leading high slots depends on the bit value and comes from `cfg_hi0` and `cfg_hi1`. Common settings are three slots (one high slot for a 0, two for a 1), four slots (one and two high) and five slots (one and four high, with 250 ns slots).

A byte is taken on a valid/ready handshake and sent most significant bit first. When it is done, the line rests low. If another byte arrives during this gap it starts at once. A low stretch of this kind is harmless because only the high time of a bit is timing-critical. If no byte arrives within `cfg_gap` cycles, the low stretch serves as the latch period of the strand and `busy` drops.

Top module: `slot_pixel_tx`

## Requirements
- R1: After reset, `line_out` is 0, `busy` is 0 and `in_ready` is 1.
- R2: A byte is sent as 8 bits, most significant bit first. A bit is read as 1 when its high time equals `cfg_hi1` slots and as 0 when it equals `cfg_hi0` slots.
- R3: `line_out` goes high in the first cycle after the accepting clock edge. The high time of a bit is exactly hi×div cycles, where 1 ≤ `cfg_hi0`, `cfg_hi1` < `cfg_slots`.
- R4: Every bit lasts exactly `cfg_slots`×div cycles, and its low part follows its high part. A byte therefore lasts 8×slots×div cycles.
- R5: `cfg_div`, `cfg_slots`, `cfg_hi0` and `cfg_hi1` are captured when a byte is accepted. Changing them while the byte is being sent does not alter that byte.
- R6: `in_ready` is 0 while a byte is being sent and 1 otherwise. Whenever `in_ready` is 1, `line_out` is 0.
- R7: After a byte, `line_out` stays low and `busy` stays 1. If no byte is accepted, `busy` falls after exactly max(1,`cfg_gap`) cycles. A byte accepted within the gap is sent without `busy` falling.
- R8: A `cfg_div` of 0 behaves as 1.
- R9: `cfg_slots` values 3, 4 and 5 are all supported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Byte offered |
| in_ready | output | 1 | Byte can be taken |
| in_data | input | 8 | Intensity byte |
| cfg_div | input | DIV_W | Clock cycles per slot |
| cfg_slots | input | 3 | Slots per bit (3 to 5) |
| cfg_hi0 | input | 3 | High slots for a 0 bit |
| cfg_hi1 | input | 3 | High slots for a 1 bit |
| cfg_gap | input | GAP_W | Idle low cycles before busy falls |
| line_out | output | 1 | Pixel data line |
| busy | output | 1 | Byte or latch gap in progress |

## Verification
The line turns high in the first cycle after the accepting edge. From then on, sample k of the byte (counted from 0) is due k cycles later. The bench samples every falling edge from that point and compares the sample with a waveform computed from the captured settings. `in_ready` is due high again exactly 8×slots×div cycles after acceptance, which the bench checks on the falling edge right after the last sample. The busy fall is counted in whole cycles from the first gap sample, and the bench expects exactly max(1,gap) of them.

// File: rtl/slot_pixel_tx.sv
module slot_pixel_tx #(
  parameter int DIV_W = 12,
  parameter int GAP_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       in_data,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic [2:0]       cfg_slots,
  input  logic [2:0]       cfg_hi0,
  input  logic [2:0]       cfg_hi1,
  input  logic [GAP_W-1:0] cfg_gap,
  output logic             line_out,
  output logic             busy
);
  typedef enum logic [1:0] {IDLE, SEND, GAP} st_t;
  st_t st;

  logic [7:0]       sh;
  logic [DIV_W-1:0] div_q, cyc;
  logic [2:0]       slots_q, hi0_q, hi1_q, slot, bitn;
  logic [GAP_W-1:0] gcnt, gap_lim;

  wire take      = in_valid && in_ready;
  wire slot_end  = cyc == div_q - DIV_W'(1);
  wire bit_end   = slot_end && slot == slots_q - 3'd1;
  assign gap_lim = (cfg_gap == '0) ? GAP_W'(1) : cfg_gap;

  assign in_ready = st != SEND;
  assign busy     = st != IDLE;
  assign line_out = (st == SEND) && (slot < (sh[7] ? hi1_q : hi0_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE; sh <= '0; div_q <= DIV_W'(1); cyc <= '0;
      slots_q <= 3'd3; hi0_q <= 3'd1; hi1_q <= 3'd2;
      slot <= '0; bitn <= '0; gcnt <= '0;
    end else if (take) begin
      st      <= SEND;
      sh      <= in_data;
      div_q   <= (cfg_div == '0) ? DIV_W'(1) : cfg_div;
      slots_q <= cfg_slots;
      hi0_q   <= cfg_hi0;
      hi1_q   <= cfg_hi1;
      cyc <= '0; slot <= '0; bitn <= '0;
    end else begin
      case (st)
        SEND: begin
          if (!slot_end) cyc <= cyc + DIV_W'(1);
          else begin
            cyc <= '0;
            if (!bit_end) slot <= slot + 3'd1;
            else begin
              slot <= '0;
              if (bitn == 3'd7) begin
                st <= GAP; gcnt <= '0;
              end else begin
                bitn <= bitn + 3'd1;
                sh   <= {sh[6:0], 1'b0};
              end
            end
          end
        end
        GAP: begin
          if (gcnt == gap_lim - GAP_W'(1)) st <= IDLE;
          else gcnt <= gcnt + GAP_W'(1);
        end
        default: ;
      endcase
    end
  end

  // R6
  ready_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !line_out);
  // R1
  idle_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!line_out && in_ready));
  // R3
  start_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> line_out);
  // R7
  busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(in_ready) && !$past(in_valid)));
  // R5
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_ready && !$past(take)) |-> ($stable(div_q) && $stable(hi0_q) && $stable(hi1_q) && $stable(slots_q)));
endmodule

// File: tb/slot_pixel_tx_tb.sv
module slot_pixel_tx_tb_top;
  localparam int CLK_P = 10;
  localparam int DIV_W = 12;
  localparam int GAP_W = 16;

  logic clk = 0, rst_n = 0, in_valid = 0;
  logic [7:0] in_data = 0;
  logic [DIV_W-1:0] cfg_div = 1;
  logic [2:0] cfg_slots = 3, cfg_hi0 = 1, cfg_hi1 = 2;
  logic [GAP_W-1:0] cfg_gap = 20;
  logic in_ready, line_out, busy;
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  slot_pixel_tx #(.DIV_W(DIV_W), .GAP_W(GAP_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .cfg_div(cfg_div), .cfg_slots(cfg_slots),
    .cfg_hi0(cfg_hi0), .cfg_hi1(cfg_hi1), .cfg_gap(cfg_gap),
    .line_out(line_out), .busy(busy));

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit exp_line(input logic [7:0] b, input int s, input int h0, input int h1, input int d, input int k);
    int per = s * d;
    int bi  = k / per;
    int w   = k % per;
    int h   = b[7-bi] ? h1 : h0;
    return w < h * d;
  endfunction

  task automatic send_byte(input logic [7:0] b, input int s, input int h0, input int h1,
                           input int d, input bit scramble, input bit cont, input string req);
    int dv, total, errs, rdy, first;
    cfg_slots = 3'(s); cfg_hi0 = 3'(h0); cfg_hi1 = 3'(h1); cfg_div = DIV_W'(d);
    in_data = b; in_valid = 1;
    while (!in_ready) @(negedge clk);
    if (cont) chk(busy == 1'b1, "R7", "busy held across gap", busy, 1);
    @(negedge clk);
    in_valid = 0;
    dv = (d == 0) ? 1 : d;
    total = 8 * s * dv; errs = 0; rdy = 0; first = -1;
    for (int k = 0; k < total; k++) begin
      if (line_out != exp_line(b, s, h0, h1, dv, k)) begin
        errs++;
        if (first < 0) first = k;
      end
      if (in_ready) rdy++;
      if (scramble && k == 1) begin
        cfg_div = DIV_W'(dv + 3); cfg_slots = 3'd5; cfg_hi0 = 3'd3; cfg_hi1 = 3'd4;
      end
      @(negedge clk);
    end
    chk(errs == 0, req, "waveform mismatches (first index in actual)", first, -1);
    chk(rdy == 0, "R6", "in_ready high during byte", rdy, 0);
    chk(in_ready && !line_out, "R4", "ready/low right after byte", {in_ready, line_out}, 2);
  endtask

  task automatic wait_gap(input int g);
    int cnt = 0, hi = 0;
    while (busy && cnt < 100000) begin
      if (line_out) hi++;
      cnt++;
      @(negedge clk);
    end
    chk(cnt == ((g == 0) ? 1 : g), "R7", "busy cycles in gap", cnt, (g == 0) ? 1 : g);
    chk(hi == 0, "R7", "line high in gap", hi, 0);
  endtask

  initial begin
    int s, h0, h1, d, g;
    logic [7:0] b;
    void'($urandom(1234));
    repeat (3) @(negedge clk);
    chk(!line_out && !busy && in_ready, "R1", "reset outputs", {line_out, busy, in_ready}, 1);
    rst_n = 1;
    @(negedge clk);
    chk(!line_out && !busy && in_ready, "R1", "outputs after release", {line_out, busy, in_ready}, 1);

    cfg_gap = 20;
    send_byte(8'hA5, 3, 1, 2, 2, 0, 0, "R2");
    wait_gap(20);
    send_byte(8'hFF, 4, 1, 2, 3, 0, 0, "R3");
    send_byte(8'h00, 4, 1, 2, 3, 0, 1, "R4");
    wait_gap(20);
    send_byte(8'h81, 3, 1, 2, 0, 0, 0, "R8");
    wait_gap(20);
    send_byte(8'h3C, 5, 1, 4, 2, 0, 0, "R9");
    send_byte(8'hC3, 3, 1, 2, 1, 0, 1, "R9");
    wait_gap(20);
    send_byte(8'h96, 4, 1, 2, 2, 1, 0, "R5");
    wait_gap(20);
    cfg_gap = 0;
    send_byte(8'h01, 3, 1, 2, 1, 0, 0, "R3");
    wait_gap(0);

    for (int r = 0; r < 25; r++) begin
      s  = 3 + int'($urandom_range(0, 2));
      h0 = 1 + int'($urandom_range(0, s - 3));
      h1 = h0 + 1 + int'($urandom_range(0, s - 2 - h0));
      d  = int'($urandom_range(1, 4));
      b  = 8'($urandom);
      g  = int'($urandom_range(1, 30));
      cfg_gap = GAP_W'(g);
      send_byte(b, s, h0, h1, d, 0, 0, "R3");
      if ($urandom_range(0, 1) == 1) begin
        b = 8'($urandom);
        send_byte(b, s, h1 - 1, h1, d, 0, 1, "R2");
      end
      wait_gap(g);
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule